// File: doc/BRIEF.md
# Banked Clock Fanout with Shared Half-Rate Divider

This block is the digital model of a clock distribution front end. It chooses one reference clock out of three candidates (a primary clock and two test clocks), then fans the chosen clock out to four output banks of unequal size. Each bank has its own rate control, so it carries either the chosen clock unchanged or a half-rate copy of it. A single divide-by-two flop, shared by every bank, makes the half-rate copy, so all half-rate banks share one phase.

One active-high input does two jobs. It clears the shared divider and it floats every output. A pulse on it after power-up, or after any change of clock source, puts all half-rate banks in the same phase. After release, the first rising edge of the chosen clock makes the half-rate outputs rise too, so full-rate and half-rate outputs switch on a common edge.

Top module: `clk_fanout_banks`

## Requirements
- R1: With `pri_sel` high the primary clock `pri_clk` is the selected clock, whatever `tst_sel` holds.
- R2: With `pri_sel` low the selected clock is `tst_clk0` when `tst_sel` is low and `tst_clk1` when `tst_sel` is high.
- R3: The banks have 2, 3, 4 and 6 outputs (A, B, C, D). Every output within one bank carries the same value at all times.
- R4: A bank whose bit in `rate_sel` is low (bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D) follows the selected clock at full rate.
- R5: A bank whose `rate_sel` bit is high carries the selected clock divided by two. It changes only on rising edges of the selected clock.
- R6: While `float_rst` is high, all 15 outputs are high impedance. While it is low, all outputs are driven.
- R7: While `float_rst` is high the divider is held at 0. The first rising edge of the selected clock after release drives every half-rate output high, together with the rising edge of the full-rate outputs.
- R8: All banks at half rate show the same phase at the same moment.
- R9: If `float_rst` is raised again after an odd number of selected-clock edges and then released, the half-rate phase restarts as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk | input | 1 | Primary reference clock |
| tst_clk0 | input | 1 | Test clock 0 |
| tst_clk1 | input | 1 | Test clock 1 |
| pri_sel | input | 1 | High picks the primary clock, low picks a test clock |
| tst_sel | input | 1 | Picks test clock 1 when high, test clock 0 when low |
| rate_sel | input | 4 | Per-bank half-rate select, bit 0 = bank A .. bit 3 = bank D |
| float_rst | input | 1 | Active high: clears the divider and floats all outputs |
| bank_a_q | output | 2 | Bank A outputs |
| bank_b_q | output | 3 | Bank B outputs |
| bank_c_q | output | 4 | Bank C outputs |
| bank_d_q | output | 6 | Bank D outputs |

## Verification
The hardest case to reach from the ports is the phase restart. Several half-rate banks are stopped at an odd edge count, and the next release must still produce a rising half-rate edge on the first selected-clock edge. The stimulus gets there by holding one configuration across two back-to-back runs of three edges, each opened by a float pulse. Random configurations, each also started from a float pulse, mix clock sources and bank rates. The float state is seen through pull-up and pull-down nets on alternate banks: a driven output can never show both pulled values at the same moment.

// File: rtl/cfb_pkg.sv
// Package: shared types for the banked clock fanout.
// Assumes: three reference sources, encoded as below.
package cfb_pkg;
    typedef enum logic [1:0] {
        SRC_TST0 = 2'd0,
        SRC_TST1 = 2'd1,
        SRC_PRI  = 2'd2
    } clk_src_e;

    localparam int NUM_BANKS = 4;
endpackage

// File: rtl/cfb_src_sel.sv
// Module: cfb_src_sel
// Picks the reference clock. Primary select has priority over the test-clock
// select. Assumes the selects change only while the outputs are floated,
// so glitches from switching reach no driven output.
module cfb_src_sel
    import cfb_pkg::*;
(
    input  logic pri_clk,
    input  logic tst_clk0,
    input  logic tst_clk1,
    input  logic pri_sel,
    input  logic tst_sel,
    output logic sel_clk
);
    clk_src_e src;

    // Decode the two select inputs into a source code.
    always_comb begin
        if (pri_sel)      src = SRC_PRI;
        else if (tst_sel) src = SRC_TST1;
        else              src = SRC_TST0;
    end

    // Route the chosen source to the shared clock net.
    always_comb begin
        case (src)
            SRC_PRI:  sel_clk = pri_clk;
            SRC_TST1: sel_clk = tst_clk1;
            default:  sel_clk = tst_clk0;
        endcase
    end
endmodule

// File: rtl/cfb_half_gen.sv
// Module: cfb_half_gen
// Shared divide-by-two toggle flop. It toggles on each rising edge of the
// selected clock. It is cleared synchronously to 0 while the float/reset
// input is high. Assumes the selected clock keeps running during reset.
module cfb_half_gen (
    input  logic sel_clk,
    input  logic float_rst,
    output logic half_clk
);
    // Toggle once per selected-clock rising edge; hold 0 during reset.
    always_ff @(posedge sel_clk) begin
        if (float_rst) half_clk <= 1'b0;
        else           half_clk <= ~half_clk;
    end
endmodule

// File: rtl/cfb_bank_drv.sv
// Module: cfb_bank_drv
// One output bank: picks full or half rate and drives WIDTH identical copies.
// Floats them all when the drive enable is low. Both rate paths come from
// the same selected-clock edge, so they switch together.
module cfb_bank_drv #(
    parameter int WIDTH = 2
) (
    input  logic             full_clk,
    input  logic             half_clk,
    input  logic             use_half,
    input  logic             drive_en,
    output logic             bank_clk,
    output wire [WIDTH-1:0]  q
);
    // Per-bank rate choice.
    always_comb bank_clk = use_half ? half_clk : full_clk;

    // Replicate onto each output pin with its own three-state driver.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign q[i] = drive_en ? bank_clk : 1'bz;
    end
endmodule

// File: rtl/clk_fanout_banks.sv
// Module: clk_fanout_banks (top)
// Clock fanout front end. It selects one of three references, runs one
// shared half-rate divider, and drives four banks of unequal width, each
// with its own rate select. float_rst (active high) clears the divider and
// floats all outputs.
module clk_fanout_banks #(
    parameter int A_W = 2,
    parameter int B_W = 3,
    parameter int C_W = 4,
    parameter int D_W = 6
) (
    input  logic            pri_clk,
    input  logic            tst_clk0,
    input  logic            tst_clk1,
    input  logic            pri_sel,
    input  logic            tst_sel,
    input  logic [3:0]      rate_sel,
    input  logic            float_rst,
    output wire [A_W-1:0]   bank_a_q,
    output wire [B_W-1:0]   bank_b_q,
    output wire [C_W-1:0]   bank_c_q,
    output wire [D_W-1:0]   bank_d_q
);
    logic       sel_clk;
    logic       half_clk;
    logic       drive_en;
    logic [3:0] bank_clk;

    // Outputs are driven only while the float/reset input is low.
    always_comb drive_en = ~float_rst;

    cfb_src_sel u_src (
        .pri_clk  (pri_clk),
        .tst_clk0 (tst_clk0),
        .tst_clk1 (tst_clk1),
        .pri_sel  (pri_sel),
        .tst_sel  (tst_sel),
        .sel_clk  (sel_clk)
    );

    cfb_half_gen u_half (
        .sel_clk   (sel_clk),
        .float_rst (float_rst),
        .half_clk  (half_clk)
    );

    cfb_bank_drv #(.WIDTH(A_W)) u_bank_a (
        .full_clk (sel_clk), .half_clk (half_clk), .use_half (rate_sel[0]),
        .drive_en (drive_en), .bank_clk (bank_clk[0]), .q (bank_a_q)
    );
    cfb_bank_drv #(.WIDTH(B_W)) u_bank_b (
        .full_clk (sel_clk), .half_clk (half_clk), .use_half (rate_sel[1]),
        .drive_en (drive_en), .bank_clk (bank_clk[1]), .q (bank_b_q)
    );
    cfb_bank_drv #(.WIDTH(C_W)) u_bank_c (
        .full_clk (sel_clk), .half_clk (half_clk), .use_half (rate_sel[2]),
        .drive_en (drive_en), .bank_clk (bank_clk[2]), .q (bank_c_q)
    );
    cfb_bank_drv #(.WIDTH(D_W)) u_bank_d (
        .full_clk (sel_clk), .half_clk (half_clk), .use_half (rate_sel[3]),
        .drive_en (drive_en), .bank_clk (bank_clk[3]), .q (bank_d_q)
    );
endmodule

// File: rtl/clk_fanout_banks_chk.sv
// Module: clk_fanout_banks_chk
// Assertion checker bound into clk_fanout_banks. It is clocked by the
// selected clock and looks at the shared divider and the per-bank clocks.
// Assumes rate selects change only while float_rst is high.
module clk_fanout_banks_chk (
    input logic       sel_clk,
    input logic       float_rst,
    input logic       half_clk,
    input logic [3:0] rate_sel,
    input logic [3:0] bank_clk
);
    logic [1:0] run_cnt;

    // Count edges since release, saturating; used to arm $past-based checks.
    always_ff @(posedge sel_clk) begin
        if (float_rst)           run_cnt <= 2'd0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    // R7
    div_clear_chk: assert property (@(posedge sel_clk)
        float_rst |=> !half_clk);

    // R5
    div_toggle_chk: assert property (@(posedge sel_clk) disable iff (float_rst)
        (run_cnt != 2'd0) |-> (half_clk != $past(half_clk)));

    for (genvar b = 0; b < 4; b++) begin : g_bank
        // R4
        full_rate_low_chk: assert property (@(posedge sel_clk) disable iff (float_rst)
            !rate_sel[b] |-> !bank_clk[b]);

        // R8
        half_phase_chk: assert property (@(posedge sel_clk) disable iff (float_rst)
            (rate_sel[b] && rate_sel[3]) |-> (bank_clk[b] == bank_clk[3]));
    end
endmodule

bind clk_fanout_banks clk_fanout_banks_chk chk_i (
    .sel_clk   (sel_clk),
    .float_rst (float_rst),
    .half_clk  (half_clk),
    .rate_sel  (rate_sel),
    .bank_clk  (bank_clk)
);

// File: tb/clk_fanout_banks_tb_top.sv
// Bench: self-checking model of the banked clock fanout. Directed corner
// cases plus seeded random configurations; expected values from functions.
module clk_fanout_banks_tb_top;
    logic       pri_clk = 1'b0;
    logic       tst_clk0 = 1'b0;
    logic       tst_clk1 = 1'b0;
    logic       pri_sel = 1'b0;
    logic       tst_sel = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       float_rst = 1'b1;

    // Pulls on alternate banks make a floated output visible (R6).
    tri1 [1:0] qa;
    tri0 [2:0] qb;
    tri1 [3:0] qc;
    tri0 [5:0] qd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    clk_fanout_banks dut_i (
        .pri_clk (pri_clk), .tst_clk0 (tst_clk0), .tst_clk1 (tst_clk1),
        .pri_sel (pri_sel), .tst_sel (tst_sel), .rate_sel (rate_sel),
        .float_rst (float_rst),
        .bank_a_q (qa), .bank_b_q (qb), .bank_c_q (qc), .bank_d_q (qd)
    );

    always #4  pri_clk  = ~pri_clk;   // 125 MHz
    always #6  tst_clk0 = ~tst_clk0;
    always #10 tst_clk1 = ~tst_clk1;

    // Expected bank bit: half-rate level if selected, else full-rate level.
    function automatic logic exp_bit(logic use_half, logic half_lvl, logic full_lvl);
        return use_half ? half_lvl : full_lvl;
    endfunction

    // Quarter period of the reference the requirements select.
    function automatic int quarter(logic p, logic t);
        if (p) return 2;
        return t ? 5 : 3;
    endfunction

    task automatic wait_ref(input logic rise);
        if (pri_sel) begin
            if (rise) @(posedge pri_clk); else @(negedge pri_clk);
        end else if (tst_sel) begin
            if (rise) @(posedge tst_clk1); else @(negedge tst_clk1);
        end else begin
            if (rise) @(posedge tst_clk0); else @(negedge tst_clk0);
        end
    endtask

    task automatic chk_bank(string tag, int w, logic [5:0] val, logic e);
        logic [5:0] want;
        want = {6{e}} & ((6'd1 << w) - 6'd1);
        checks++;
        if (val != want) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, val, want);
        end
    endtask

    // All banks against expected levels (R3 copies, R4/R5 rate, R1/R2 source).
    task automatic chk_all(string tag, logic half_lvl, logic full_lvl);
        chk_bank(tag, 2, {4'd0, qa}, exp_bit(rate_sel[0], half_lvl, full_lvl));
        chk_bank(tag, 3, {3'd0, qb}, exp_bit(rate_sel[1], half_lvl, full_lvl));
        chk_bank(tag, 4, {2'd0, qc}, exp_bit(rate_sel[2], half_lvl, full_lvl));
        chk_bank(tag, 6, qd,         exp_bit(rate_sel[3], half_lvl, full_lvl));
    endtask

    // Float, configure, release, then check `edges` selected-clock cycles.
    task automatic run_cfg(logic p, logic t, logic [3:0] r, int edges, string tag);
        int q;
        float_rst = 1'b1;
        #1;
        // R6: pulled-up banks read 1, pulled-down banks read 0 while floated
        chk_bank("R6 float A", 2, {4'd0, qa}, 1'b1);
        chk_bank("R6 float B", 3, {3'd0, qb}, 1'b0);
        chk_bank("R6 float C", 4, {2'd0, qc}, 1'b1);
        chk_bank("R6 float D", 6, qd,         1'b0);
        pri_sel = p; tst_sel = t; rate_sel = r;
        q = quarter(p, t);
        repeat (3) wait_ref(1'b1);
        wait_ref(1'b0);
        #1 float_rst = 1'b0;
        for (int k = 1; k <= edges; k++) begin
            wait_ref(1'b1);
            #q;
            // R7: first edge after release raises half rate; R8 shared phase
            chk_all(tag, logic'(k % 2), 1'b1);
            wait_ref(1'b0);
            #q;
            chk_all(tag, logic'(k % 2), 1'b0);
        end
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd1357);
        #20;
        // R6: reset state, all outputs floated
        chk_bank("R6 reset A", 2, {4'd0, qa}, 1'b1);
        chk_bank("R6 reset D", 6, qd,         1'b0);
        run_cfg(1'b1, 1'b0, 4'b0000, 4, "R1 R4 primary full");
        run_cfg(1'b1, 1'b1, 4'b1111, 4, "R1 R5 R8 primary half");
        run_cfg(1'b0, 1'b0, 4'b0101, 4, "R2 R3 tst0 mixed");
        run_cfg(1'b0, 1'b1, 4'b1010, 4, "R2 R3 tst1 mixed");
        run_cfg(1'b1, 1'b0, 4'b1101, 3, "R7 odd stop");
        run_cfg(1'b1, 1'b0, 4'b1101, 3, "R9 restart");
        for (int i = 0; i < 20; i++) begin
            run_cfg(1'($urandom_range(1)), 1'($urandom_range(1)),
                    4'($urandom_range(15)), 1 + $urandom_range(5), "R1 R2 R4 R5 random");
        end
        float_rst = 1'b1;
        #1 chk_bank("R6 final float B", 3, {3'd0, qb}, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge pri_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule